// File: doc/BRIEF.md
# Triggered byte DMA channel

This block is one channel of a direct memory access engine that copies a single byte for each start event. The source is usually a buffer in memory and the destination is usually one output data register, such as a DAC input or a port latch. A timer or another peripheral supplies the start pulses, so the rate of the output stream is set by that source and not by the speed of the bus. Software can also start the channel directly. In that case it copies bytes back to back until the source region has been read once.

The source and the destination each have their own start address, message size, counter and address-increment choice. When either counter reaches its message size, it reloads to zero, so the address returns to the start address, and a sticky completion flag is set for that side. An abort input, if enabled, stops the channel at once. A start event that arrives while a byte is still in flight sets an overrun flag and is otherwise dropped.

The control state machine has three states:
- IDLE moves to READ on a start event, or on a pending software run when trigger pacing is off.
- READ always moves to WRITE.
- WRITE always returns to IDLE.
- Clearing the enable, or an abort, forces IDLE from any state.

Top module: `trig_byte_dma`

## Requirements
- R1: After reset, the four flags, `irq`, `go`, `rd_req` and `wr_req` are all 0.
- R2: Each start event moves exactly one byte. A read is issued at the current source address. The byte returned one cycle later is written to the current destination address in the following cycle.
- R3: When `src_inc`=1, the source address is `src_base` plus the number of bytes moved since the last reload; when `src_inc`=0 it stays at `src_base`. `dst_inc` and `dst_base` work the same way for the destination.
- R4: After `src_size` bytes, the source counter reloads so the next read is at `src_base`, and flag bit 0 (source complete) is set.
- R5: After `dst_size` bytes, the destination counter reloads so the next write is at `dst_base`, and flag bit 1 (destination complete) is set.
- R6: A start event that arrives while the state is READ or WRITE sets flag bit 3 (overrun) and moves no extra byte.
- R7: When `cfg_abort_en`=1, a rising edge on the input chosen by `abort_sel` does four things: it returns the channel to IDLE, clears `go`, resets both counters and sets flag bit 2 (abort). When `cfg_abort_en`=0, that edge has no effect.
- R8: When `cfg_trig_en`=0, a `sw_go` pulse sets `go` and moves bytes back to back. After `src_size` bytes it stops and clears `go`.
- R9: When `cfg_trig_en`=1, a start event sets `go`, and `go` stays set when the source count completes.
- R10: While `cfg_en`=0, no bus request is made and both counters are held at zero. After re-enabling, the first byte uses the two start addresses.
- R11: When `cfg_trig_en`=0, start-input edges move no byte.
- R12: Flags are sticky until a 1 is written to the matching bit of `flag_clr`. `irq` is the OR of the flags masked by `irq_en`.
- R13: A start event is a rising edge on `trig_in[start_sel]`. Edges on the other inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_trig_en | input | 1 | Start-trigger pacing enable |
| cfg_abort_en | input | 1 | Abort-trigger enable |
| sw_go | input | 1 | Software start pulse |
| src_inc | input | 1 | Source address increments |
| dst_inc | input | 1 | Destination address increments |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| src_size | input | SW | Source message size in bytes (1 or more) |
| dst_size | input | SW | Destination message size in bytes (1 or more) |
| start_sel | input | TSW | Index of the start-trigger input |
| abort_sel | input | TSW | Index of the abort-trigger input |
| irq_en | input | 4 | Per-flag interrupt enable |
| flag_clr | input | 4 | Write-1-to-clear strobe for the flags |
| trig_in | input | NTRIG | Trigger inputs |
| rd_req | output | 1 | Bus read request |
| rd_addr | output | AW | Bus read address |
| rd_data | input | DW | Read data, valid one cycle after `rd_req` |
| wr_req | output | 1 | Bus write request |
| wr_addr | output | AW | Bus write address |
| wr_data | output | DW | Bus write data |
| flags | output | 4 | Sticky flags: bit 0 source, bit 1 destination, bit 2 abort, bit 3 overrun |
| irq | output | 1 | Combined interrupt |
| go | output | 1 | Transfer in progress |

## Verification
Cycle timing of the results:
- A start edge that is present before clock edge 1 gives READ after edge 1 and WRITE after edge 2.
- The counters and flags change at edge 3.
- A software pulse adds one extra edge before the first READ. After that, each further byte takes three edges.

Because of this timing, every scenario task drives inputs on falling edges and then waits at least four falling edges before it samples flags, `go` or the write log. The overrun test places its second rising edge exactly at edge 3, while the state is WRITE. The write log is filled at each rising edge where `wr_req` is high, so its count shows precisely how many bytes a stimulus moved.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    localparam int NFLAG   = 4;
    localparam int FLG_SRC = 0;
    localparam int FLG_DST = 1;
    localparam int FLG_ABT = 2;
    localparam int FLG_OVR = 3;
endpackage

// File: rtl/dma_trig_pick.sv
module dma_trig_pick #(
    parameter int N    = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    trig_in,
    input  logic [SELW-1:0] sel,
    output logic            rise
);
    logic picked;
    logic picked_q;

    assign picked = trig_in[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) picked_q <= 1'b0;
        else        picked_q <= picked;
    end

    assign rise = picked & ~picked_q;
endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
    parameter int AW = 16,
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] size,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          wrap
);
    logic [SW-1:0] cnt;

    assign wrap = (cnt == size - SW'(1));
    assign addr = inc ? (base + AW'(cnt)) : base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (step) begin
            if (wrap)        cnt <= '0;
            else             cnt <= cnt + SW'(1);
        end
    end

    // R4 / R5: a completing step brings the address back to the base
    p_reload_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap && !clear) |=> (addr == base || !$stable(base)));

    // R10: a clear leaves the counter at zero
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/dma_flags.sv
module dma_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & ie);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R12: a flag stays until it is cleared
        p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
        p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/trig_byte_dma.sv
module trig_byte_dma
    import dma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SW    = 12,
    parameter int DW    = 8,
    parameter int NTRIG = 8,
    localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_trig_en,
    input  logic             cfg_abort_en,
    input  logic             sw_go,
    input  logic             src_inc,
    input  logic             dst_inc,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [SW-1:0]    src_size,
    input  logic [SW-1:0]    dst_size,
    input  logic [TSW-1:0]   start_sel,
    input  logic [TSW-1:0]   abort_sel,
    input  logic [NFLAG-1:0] irq_en,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NTRIG-1:0] trig_in,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_req,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic             go
);
    dma_state_e state_q, state_d;
    logic run_q, run_d;
    logic start_rise, abort_rise;
    logic abort_hit, start_req, free_req, overrun, step, clr_cnt;
    logic src_wrap, dst_wrap;
    logic [AW-1:0] src_addr, dst_addr;
    logic [NFLAG-1:0] flag_set;

    dma_trig_pick #(.N(NTRIG), .SELW(TSW)) u_start_pick (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(start_sel), .rise(start_rise)
    );
    dma_trig_pick #(.N(NTRIG), .SELW(TSW)) u_abort_pick (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(abort_sel), .rise(abort_rise)
    );

    assign abort_hit = cfg_en & cfg_abort_en & abort_rise;
    assign start_req = cfg_en & cfg_trig_en & start_rise;
    assign free_req  = run_q & ~cfg_trig_en;
    assign overrun   = start_req & (state_q != ST_IDLE) & ~abort_hit;
    assign clr_cnt   = ~cfg_en | abort_hit;

    dma_addr_track #(.AW(AW), .SW(SW)) u_src_track (
        .clk(clk), .rst_n(rst_n), .clear(clr_cnt), .step(step),
        .base(src_base), .size(src_size), .inc(src_inc),
        .addr(src_addr), .wrap(src_wrap)
    );
    dma_addr_track #(.AW(AW), .SW(SW)) u_dst_track (
        .clk(clk), .rst_n(rst_n), .clear(clr_cnt), .step(step),
        .base(dst_base), .size(dst_size), .inc(dst_inc),
        .addr(dst_addr), .wrap(dst_wrap)
    );

    dma_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
        .ie(irq_en), .flags(flags), .irq(irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (clr_cnt) begin
            state_d = ST_IDLE;
            run_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_req || free_req) state_d = ST_READ;
                ST_READ:  state_d = ST_WRITE;
                ST_WRITE: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
            if (sw_go || start_req)
                run_d = 1'b1;
            else if (state_q == ST_WRITE && src_wrap && !cfg_trig_en)
                run_d = 1'b0;
        end
    end

    // outputs
    always_comb begin
        rd_req   = (state_q == ST_READ)  && !clr_cnt;
        wr_req   = (state_q == ST_WRITE) && !clr_cnt;
        step     = wr_req;
        rd_addr  = src_addr;
        wr_addr  = dst_addr;
        wr_data  = rd_data;
        go       = run_q;
        flag_set = '0;
        flag_set[FLG_SRC] = step & src_wrap;
        flag_set[FLG_DST] = step & dst_wrap;
        flag_set[FLG_ABT] = abort_hit;
        flag_set[FLG_OVR] = overrun;
    end

    // R2: a read is always followed by its write
    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cfg_en && !abort_hit) |=> (state_q == ST_WRITE));
    p_single_bus_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R6: trigger during a pending byte raises overrun
    p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state_q != ST_IDLE && !abort_hit) |=> flags[FLG_OVR]);
    // R7: abort stops the channel
    p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (state_q == ST_IDLE && !go && flags[FLG_ABT]));
    // R10: disabled channel is idle and silent
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!go && !rd_req && !wr_req));
endmodule

// File: tb/trig_byte_dma_test.sv
module trig_byte_dma_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en, cfg_trig_en, cfg_abort_en, sw_go, src_inc, dst_inc;
    logic [15:0] src_base, dst_base;
    logic [11:0] src_size, dst_size;
    logic [2:0]  start_sel, abort_sel;
    logic [3:0]  irq_en, flag_clr;
    logic [7:0]  trig_in;
    logic        rd_req, wr_req;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;
    logic [3:0]  flags;
    logic        irq, go;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] wlog_a [0:63];
    logic [7:0]  wlog_d [0:63];
    int nw = 0;

    always #2.5 clk = ~clk;

    trig_byte_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_trig_en(cfg_trig_en),
        .cfg_abort_en(cfg_abort_en), .sw_go(sw_go), .src_inc(src_inc), .dst_inc(dst_inc),
        .src_base(src_base), .dst_base(dst_base), .src_size(src_size), .dst_size(dst_size),
        .start_sel(start_sel), .abort_sel(abort_sel), .irq_en(irq_en), .flag_clr(flag_clr),
        .trig_in(trig_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags),
        .irq(irq), .go(go)
    );

    // memory model: one-cycle read latency, content = low address byte xor 0x5A
    always @(posedge clk) if (rd_req) rd_data <= rd_addr[7:0] ^ 8'h5A;

    always @(posedge clk) begin
        if (wr_req && nw < 64) begin
            wlog_a[nw] <= wr_addr;
            wlog_d[nw] <= wr_data;
            nw <= nw + 1;
        end
    end

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int idx);
        @(negedge clk) trig_in[idx] = 1'b1;
        @(negedge clk) trig_in[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk) cfg_en = 1'b0;
        @(negedge clk) cfg_en = 1'b1;
    endtask

    task automatic clear_flags();
        @(negedge clk) flag_clr = 4'hF;
        @(negedge clk) flag_clr = 4'h0;
    endtask

    task automatic t_reset();
        check("R1 flags", flags, 4'h0);
        check("R1 irq", irq, 1'b0);
        check("R1 go", go, 1'b0);
        check("R1 rd_req", rd_req, 1'b0);
        check("R1 wr_req", wr_req, 1'b0);
    endtask

    // R2 R3 R4 R5 R9 R12: paced stream with both wraps
    task automatic t_stream();
        int b;
        restart();
        b = nw;
        pulse(2);
        check("R2 count", nw - b, 1);
        check("R2 data", wlog_d[b], mem(16'h0010));
        check("R3 dst addr", wlog_a[b], 16'h0200);
        pulse(2);
        check("R3 src inc data", wlog_d[b+1], mem(16'h0011));
        check("R3 dst inc addr", wlog_a[b+1], 16'h0201);
        check("R5 dst flag", flags, 4'b0010);
        pulse(2);
        check("R4 src flag", flags, 4'b0011);
        check("R5 dst reload addr", wlog_a[b+2], 16'h0200);
        check("R9 go kept", go, 1'b1);
        pulse(2);
        check("R4 src reload data", wlog_d[b+3], mem(16'h0010));
        check("R12 irq", irq, 1'b1);
        @(negedge clk) irq_en = 4'h0;
        #1 check("R12 irq masked", irq, 1'b0);
        check("R12 flags sticky", flags, 4'b0011);
        clear_flags();
        check("R12 cleared", flags, 4'h0);
        irq_en = 4'hF;
    endtask

    // R3: fixed source address
    task automatic t_fixed_src();
        int b;
        src_inc = 1'b0;
        restart();
        b = nw;
        pulse(2);
        pulse(2);
        check("R3 fixed src data", wlog_d[b+1], mem(16'h0010));
        src_inc = 1'b1;
    endtask

    // R13 R11 R10: ignored starts
    task automatic t_ignored();
        int b;
        restart();
        b = nw;
        pulse(5);
        check("R13 other input", nw - b, 0);
        cfg_trig_en = 1'b0;
        pulse(2);
        check("R11 trig disabled", nw - b, 0);
        cfg_trig_en = 1'b1;
        @(negedge clk) cfg_en = 1'b0;
        pulse(2);
        check("R10 disabled no byte", nw - b, 0);
        check("R10 disabled go", go, 1'b0);
        @(negedge clk) cfg_en = 1'b1;
        pulse(2);
        check("R10 first byte from base", wlog_d[b], mem(16'h0010));
        check("R10 first addr base", wlog_a[b], 16'h0200);
    endtask

    // R6: second edge at the write cycle
    task automatic t_overrun();
        int b;
        restart();
        clear_flags();
        b = nw;
        @(negedge clk) trig_in[2] = 1'b1;
        @(negedge clk) trig_in[2] = 1'b0;
        @(negedge clk) trig_in[2] = 1'b1;
        @(negedge clk) trig_in[2] = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 one byte only", nw - b, 1);
        check("R6 overrun flag", flags[3], 1'b1);
    endtask

    // R7: abort gated by enable, then resets counters
    task automatic t_abort();
        int b;
        restart();
        clear_flags();
        b = nw;
        pulse(2);
        cfg_abort_en = 1'b0;
        pulse(4);
        check("R7 abort ignored flag", flags[2], 1'b0);
        check("R7 abort ignored go", go, 1'b1);
        cfg_abort_en = 1'b1;
        pulse(4);
        check("R7 abort flag", flags[2], 1'b1);
        check("R7 abort clears go", go, 1'b0);
        pulse(2);
        check("R7 counter reset data", wlog_d[b+1], mem(16'h0010));
        check("R7 counter reset addr", wlog_a[b+1], 16'h0200);
        cfg_abort_en = 1'b0;
    endtask

    // R8 R3: software-started free run with fixed destination
    task automatic t_swgo();
        int b;
        cfg_trig_en = 1'b0;
        dst_inc = 1'b0;
        dst_size = 12'd8;
        restart();
        clear_flags();
        b = nw;
        @(negedge clk) sw_go = 1'b1;
        @(negedge clk) sw_go = 1'b0;
        repeat (15) @(negedge clk);
        check("R8 byte count", nw - b, 3);
        check("R8 data 0", wlog_d[b], mem(16'h0010));
        check("R8 data 2", wlog_d[b+2], mem(16'h0012));
        check("R3 fixed dst", wlog_a[b+2], 16'h0200);
        check("R8 go cleared", go, 1'b0);
        check("R8 src flag", flags[0], 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_en = 1'b0; cfg_trig_en = 1'b1; cfg_abort_en = 1'b0; sw_go = 1'b0;
        src_inc = 1'b1; dst_inc = 1'b1;
        src_base = 16'h0010; dst_base = 16'h0200;
        src_size = 12'd3; dst_size = 12'd2;
        start_sel = 3'd2; abort_sel = 3'd4;
        irq_en = 4'hF; flag_clr = 4'h0; trig_in = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_en = 1'b1;
        t_stream();
        t_fixed_src();
        t_ignored();
        t_overrun();
        t_abort();
        t_swgo();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule